// File: doc/BRIEF.md
# Scatter-Gather Descriptor List Walker

This block walks a chain of scatter-gather descriptors in memory and hands the segments they describe, one at a time, to a downstream hash engine. A start pulse carries either the base address of a descriptor list or, when list mode is off, the address and length of one contiguous source buffer. In list mode the walker reads two words for each descriptor, over a simple single-outstanding memory read port: first a length word, then an address word. It masks both fields and presents the resulting segment on a valid/ready output.

The flag carried in a length word only ends the current walk. It does not say whether the overall message is complete; that is for the consumer to decide. A list that never sets the flag is cut off after a fixed number of entries, and a sticky error bit is raised. If the start command asked for it, a one-cycle interrupt pulse marks the end of each walk.

Top module: `sgw_walker`

## Requirements
- R1: While reset is held and after it is released, busy, seg_valid, mem_req, irq and err are all low.
- R2: With list mode on, the descriptor at byte address P is read as the length word at P and then the address word at P+4, in that order. The next descriptor is at P+8.
- R3: Bit 31 of a length word is the end-of-walk flag and is output on seg_last. Bits 30:0 are the byte length and are output on seg_len.
- R4: Bit 31 of an address word is discarded. seg_addr carries bits 30:0.
- R5: The walk ends at the handshake of the segment whose flag is set. No further memory read is issued after it, and busy then reads low.
- R6: With list mode off, exactly one segment is emitted, with seg_addr = cmd_base[30:0], seg_len = cmd_len and seg_last = 1. No memory read is issued.
- R7: While seg_valid is high and seg_ready is low, seg_valid stays high and seg_addr, seg_len and seg_last hold their values.
- R8: A start pulse that arrives while busy is high is ignored, including one in the cycle of the final handshake.
- R9: If cmd_irq_en was set when the walk was accepted, irq is high for exactly one cycle, the first cycle in which busy reads low after the walk. Otherwise irq stays low.
- R10: If MAX_ENT segments have been handed over without the flag, the walk stops, err is set, and err stays set until the next accepted start clears it.
- R11: If the flag is set on entry number MAX_ENT, the walk ends normally and err stays low.
- R12: While mem_req is high and no mem_rvalid has come back, mem_req stays high and mem_addr stays stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_go | input | 1 | Start pulse, taken only when idle |
| cmd_list_en | input | 1 | 1: cmd_base points to a descriptor list; 0: single buffer |
| cmd_irq_en | input | 1 | Request an interrupt pulse when the walk ends |
| cmd_base | input | 32 | List base address, or buffer address in single mode |
| cmd_len | input | 31 | Buffer length in single mode |
| mem_req | output | 1 | Memory read request, held until answered |
| mem_addr | output | 32 | Byte address of the word being read |
| mem_rvalid | input | 1 | Read data valid, one cycle per request |
| mem_rdata | input | 32 | Read data |
| seg_valid | output | 1 | Segment available |
| seg_ready | input | 1 | Consumer accepts the segment |
| seg_addr | output | 31 | Segment base address |
| seg_len | output | 31 | Segment byte length |
| seg_last | output | 1 | End-of-walk flag of this segment |
| busy | output | 1 | A walk is in progress |
| irq | output | 1 | One-cycle completion pulse |
| err | output | 1 | Sticky: list ended at the entry limit without a flag |

## Verification
The flag and the entry limit can both fall on the same descriptor. In that case the flag has to win, and the walk must end cleanly with no error. The bench provokes this with a list of exactly MAX_ENT entries whose final entry carries the flag. It judges the result by the segment count, the final seg_last, err staying low and a single irq pulse. It also runs the same list with the flag removed, where err must rise instead. A second collision puts a start pulse in the very cycle of the final handshake. There the bench checks that no extra memory read or segment follows and that busy stays low.

// File: rtl/sgw_pkg.sv
`timescale 1ns/1ps
package sgw_pkg;
  localparam int unsigned WORD_W     = 32;
  localparam int unsigned FIELD_W    = WORD_W - 1;
  localparam int unsigned WORD_BYTES = WORD_W / 8;
  localparam int unsigned DESC_BYTES = 2 * WORD_BYTES;

  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_EMIT} walk_st_t;
  typedef enum logic [1:0] {PH_IDLE, PH_LEN, PH_ADR} fetch_ph_t;

  typedef struct packed {
    logic               last;
    logic [FIELD_W-1:0] len;
    logic [FIELD_W-1:0] addr;
  } seg_t;
endpackage

// File: rtl/sgw_rst_sync.sv
`timescale 1ns/1ps
module sgw_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/sgw_fetch.sv
`timescale 1ns/1ps
module sgw_fetch import sgw_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_go,
  input  logic [WORD_W-1:0] fetch_base,
  output logic              mem_req,
  output logic [WORD_W-1:0] mem_addr,
  input  logic              mem_rvalid,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              desc_valid,
  output seg_t              desc
);
  fetch_ph_t          ph_q, ph_d;
  logic [WORD_W-1:0]  base_q;
  logic [FIELD_W-1:0] len_q;
  logic               last_q;
  logic               base_en, len_en;
  logic               unused_addr_msb;

  always_comb begin
    ph_d    = ph_q;
    base_en = 1'b0;
    len_en  = 1'b0;
    case (ph_q)
      PH_IDLE: if (fetch_go)   begin ph_d = PH_LEN;  base_en = 1'b1; end
      PH_LEN:  if (mem_rvalid) begin ph_d = PH_ADR;  len_en  = 1'b1; end
      PH_ADR:  if (mem_rvalid) begin ph_d = PH_IDLE; end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      base_q <= '0;
      len_q  <= '0;
      last_q <= 1'b0;
    end else begin
      ph_q <= ph_d;
      if (base_en) base_q <= fetch_base;
      if (len_en) begin
        len_q  <= mem_rdata[FIELD_W-1:0];
        last_q <= mem_rdata[WORD_W-1];
      end
    end
  end

  assign mem_req         = (ph_q != PH_IDLE);
  assign mem_addr        = (ph_q == PH_ADR) ? base_q + WORD_W'(WORD_BYTES) : base_q;
  assign desc_valid      = (ph_q == PH_ADR) && mem_rvalid;
  assign desc.last       = last_q;
  assign desc.len        = len_q;
  assign desc.addr       = mem_rdata[FIELD_W-1:0];
  assign unused_addr_msb = mem_rdata[WORD_W-1];

  // R12: request and address held until answered
  p_mem_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));

  // R2: address word read right after length word, 4 bytes above it
  p_fetch_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_LEN && mem_rvalid) |=> (mem_req && mem_addr == $past(mem_addr) + WORD_W'(WORD_BYTES)));
endmodule

// File: rtl/sgw_out.sv
`timescale 1ns/1ps
module sgw_out import sgw_pkg::*; (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  seg_t load_seg,
  input  logic seg_ready,
  output logic seg_valid,
  output seg_t seg,
  output logic seg_fire
);
  logic valid_q, valid_d;
  seg_t seg_q;
  logic seg_en;

  always_comb begin
    valid_d = valid_q;
    seg_en  = load;
    if (load)                      valid_d = 1'b1;
    else if (valid_q && seg_ready) valid_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      seg_q   <= '0;
    end else begin
      valid_q <= valid_d;
      if (seg_en) seg_q <= load_seg;
    end
  end

  assign seg_valid = valid_q;
  assign seg       = seg_q;
  assign seg_fire  = valid_q && seg_ready;

  // R7: a stalled segment holds still
  p_seg_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !seg_ready) |=> (valid_q && $stable(seg_q)));

  // R7: a new segment never overwrites one still pending
  p_load_free_r7: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !valid_q);
endmodule

// File: rtl/sgw_seq.sv
`timescale 1ns/1ps
module sgw_seq import sgw_pkg::*; #(
  parameter int unsigned MAX_ENT = 256
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_go,
  input  logic               cmd_list_en,
  input  logic               cmd_irq_en,
  input  logic [WORD_W-1:0]  cmd_base,
  input  logic [FIELD_W-1:0] cmd_len,
  output logic               fetch_go,
  output logic [WORD_W-1:0]  fetch_base,
  input  logic               desc_valid,
  input  seg_t               desc,
  output logic               out_load,
  output seg_t               out_seg,
  input  logic               seg_fire,
  input  logic               seg_last,
  output logic               busy,
  output logic               irq,
  output logic               err
);
  localparam int unsigned CNT_W = (MAX_ENT > 1) ? $clog2(MAX_ENT) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(MAX_ENT - 1);

  walk_st_t          st_q, st_d;
  logic [WORD_W-1:0] ptr_q;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              irq_en_q, err_q, irq_q;
  logic              accept, step, finish, err_set;

  always_comb begin
    st_d       = st_q;
    accept     = 1'b0;
    step       = 1'b0;
    finish     = 1'b0;
    err_set    = 1'b0;
    fetch_go   = 1'b0;
    fetch_base = cmd_base;
    out_load   = 1'b0;
    out_seg    = desc;
    case (st_q)
      ST_IDLE: if (cmd_go) begin
        accept = 1'b1;
        if (cmd_list_en) begin
          fetch_go = 1'b1;
          st_d     = ST_FETCH;
        end else begin
          out_load     = 1'b1;
          out_seg.last = 1'b1;
          out_seg.len  = cmd_len;
          out_seg.addr = cmd_base[FIELD_W-1:0];
          st_d         = ST_EMIT;
        end
      end
      ST_FETCH: if (desc_valid) begin
        out_load = 1'b1;
        st_d     = ST_EMIT;
      end
      ST_EMIT: if (seg_fire) begin
        if (seg_last) begin
          finish = 1'b1;
          st_d   = ST_IDLE;
        end else if (cnt_q == CNT_LAST) begin
          finish  = 1'b1;
          err_set = 1'b1;
          st_d    = ST_IDLE;
        end else begin
          step       = 1'b1;
          fetch_go   = 1'b1;
          fetch_base = ptr_q + WORD_W'(DESC_BYTES);
          st_d       = ST_FETCH;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    cnt_d = cnt_q;
    if (accept)    cnt_d = '0;
    else if (step) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      ptr_q    <= '0;
      cnt_q    <= '0;
      irq_en_q <= 1'b0;
      err_q    <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      irq_q <= finish && irq_en_q;
      if (fetch_go) ptr_q    <= fetch_base;
      if (accept)   irq_en_q <= cmd_irq_en;
      if (accept)       err_q <= 1'b0;
      else if (err_set) err_q <= 1'b1;
    end
  end

  assign busy = (st_q != ST_IDLE);
  assign irq  = irq_q;
  assign err  = err_q;

  // R9: the completion pulse lasts one cycle
  p_irq_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q);

  // R10: the error only rises after the final permitted entry
  p_err_limit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) |-> ($past(cnt_q) == CNT_LAST));

  // R11: a flagged segment always ends cleanly
  p_flag_clean_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_EMIT && seg_fire && seg_last) |=> (!err_q && st_q == ST_IDLE));

  // R8: a start during a fetch leaves the walk state alone
  p_busy_cmd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_FETCH && cmd_go && !desc_valid) |=> ($stable(ptr_q) && $stable(cnt_q)));
endmodule

// File: rtl/sgw_walker.sv
`timescale 1ns/1ps
module sgw_walker import sgw_pkg::*; #(
  parameter int unsigned MAX_ENT = 256
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_go,
  input  logic               cmd_list_en,
  input  logic               cmd_irq_en,
  input  logic [WORD_W-1:0]  cmd_base,
  input  logic [FIELD_W-1:0] cmd_len,
  output logic               mem_req,
  output logic [WORD_W-1:0]  mem_addr,
  input  logic               mem_rvalid,
  input  logic [WORD_W-1:0]  mem_rdata,
  output logic               seg_valid,
  input  logic               seg_ready,
  output logic [FIELD_W-1:0] seg_addr,
  output logic [FIELD_W-1:0] seg_len,
  output logic               seg_last,
  output logic               busy,
  output logic               irq,
  output logic               err
);
  logic              rst_sync_n;
  logic              fetch_go, desc_valid, out_load, seg_fire;
  logic [WORD_W-1:0] fetch_base;
  seg_t              desc, out_seg, seg;

  sgw_rst_sync u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  sgw_seq #(.MAX_ENT(MAX_ENT)) u_seq (
    .clk(clk), .rst_n(rst_sync_n),
    .cmd_go(cmd_go), .cmd_list_en(cmd_list_en), .cmd_irq_en(cmd_irq_en),
    .cmd_base(cmd_base), .cmd_len(cmd_len),
    .fetch_go(fetch_go), .fetch_base(fetch_base),
    .desc_valid(desc_valid), .desc(desc),
    .out_load(out_load), .out_seg(out_seg),
    .seg_fire(seg_fire), .seg_last(seg.last),
    .busy(busy), .irq(irq), .err(err)
  );

  sgw_fetch u_fetch (
    .clk(clk), .rst_n(rst_sync_n),
    .fetch_go(fetch_go), .fetch_base(fetch_base),
    .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .desc_valid(desc_valid), .desc(desc)
  );

  sgw_out u_out (
    .clk(clk), .rst_n(rst_sync_n),
    .load(out_load), .load_seg(out_seg), .seg_ready(seg_ready),
    .seg_valid(seg_valid), .seg(seg), .seg_fire(seg_fire)
  );

  assign seg_addr = seg.addr;
  assign seg_len  = seg.len;
  assign seg_last = seg.last;

  // R5: an idle walker neither reads nor offers segments
  p_idle_quiet_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !busy |-> (!seg_valid && !mem_req));
endmodule

// File: tb/tb_sgw_walker.sv
`timescale 1ns/1ps
module tb_sgw_walker;
  localparam int NENT = 16;
  localparam int MEMW = 1024;
  localparam int LOGN = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_go = 1'b0, cmd_list_en = 1'b0, cmd_irq_en = 1'b0;
  logic [31:0] cmd_base = '0;
  logic [30:0] cmd_len = '0;
  logic        mem_req, mem_rvalid = 1'b0;
  logic [31:0] mem_addr, mem_rdata = '0;
  logic        seg_valid, seg_ready = 1'b0, seg_last, busy, irq, err;
  logic [30:0] seg_addr, seg_len;

  always #2.5 clk = ~clk;

  sgw_walker #(.MAX_ENT(NENT)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_go(cmd_go), .cmd_list_en(cmd_list_en),
    .cmd_irq_en(cmd_irq_en), .cmd_base(cmd_base), .cmd_len(cmd_len),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .seg_valid(seg_valid), .seg_ready(seg_ready),
    .seg_addr(seg_addr), .seg_len(seg_len), .seg_last(seg_last),
    .busy(busy), .irq(irq), .err(err)
  );

  logic [31:0] mem [MEMW];
  int n_chk = 0, n_fail = 0;
  int lat = 0, rdy_mode = 0;
  int n_rd = 0, n_got = 0, n_irq = 0, hold_bad = 0, memhold_bad = 0, irq_busy_bad = 0;
  logic [31:0] rd_log [LOGN];
  logic [30:0] got_a [LOGN];
  logic [30:0] got_l [LOGN];
  logic        got_f [LOGN];
  logic [30:0] exp_a [LOGN];
  logic [30:0] exp_l [LOGN];
  logic        exp_f [LOGN];
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  // memory responder
  initial begin
    int w = 0;
    logic pend = 1'b0;
    logic [31:0] pa = '0;
    forever begin
      @(negedge clk);
      if (mem_rvalid) mem_rvalid = 1'b0;
      else if (mem_req) begin
        if (pend && mem_addr != pa) memhold_bad++;
        pend = 1'b1;
        pa = mem_addr;
        if (w >= lat) begin
          mem_rdata = mem[(mem_addr >> 2) % MEMW];
          mem_rvalid = 1'b1;
          if (n_rd < LOGN) rd_log[n_rd] = mem_addr;
          n_rd++;
          w = 0;
          pend = 1'b0;
        end else w++;
      end
    end
  end

  // segment sink
  initial begin
    int cyc = 0;
    logic pv = 1'b0, pf = 1'b0;
    logic [30:0] pa = '0, pl = '0;
    forever begin
      @(negedge clk);
      cyc++;
      case (rdy_mode)
        0:       seg_ready = 1'b1;
        1:       seg_ready = cyc[0];
        default: seg_ready = (cyc % 3 == 0);
      endcase
      if (pv && (!seg_valid || seg_addr != pa || seg_len != pl || seg_last != pf)) hold_bad++;
      pv = seg_valid && !seg_ready;
      pa = seg_addr; pl = seg_len; pf = seg_last;
      if (seg_valid && seg_ready) begin
        if (n_got < LOGN) begin
          got_a[n_got] = seg_addr; got_l[n_got] = seg_len; got_f[n_got] = seg_last;
        end
        n_got++;
      end
      if (irq) begin
        n_irq++;
        if (busy) irq_busy_bad++;
      end
    end
  end

  task automatic put(input int a, input logic [31:0] lw, input logic [31:0] aw);
    mem[(a >> 2) % MEMW] = lw;
    mem[((a + 4) >> 2) % MEMW] = aw;
  endtask

  task automatic clear();
    n_rd = 0; n_got = 0; n_irq = 0; hold_bad = 0; memhold_bad = 0; irq_busy_bad = 0;
  endtask

  task automatic launch(input bit list, input bit ie, input logic [31:0] base, input logic [30:0] len);
    @(negedge clk);
    cmd_list_en = list; cmd_irq_en = ie; cmd_base = base; cmd_len = len; cmd_go = 1'b1;
    @(negedge clk);
    cmd_go = 1'b0;
  endtask

  task automatic wait_idle();
    int k = 0;
    while (busy && k < 5000) begin @(negedge clk); k++; end
    repeat (3) @(negedge clk);
  endtask

  task automatic cmp_segs(input int n, input string req);
    chk(n_got == n, req, n_got, n);
    for (int i = 0; i < n && i < LOGN; i++) begin
      chk(got_a[i] == exp_a[i], req, got_a[i], exp_a[i]);
      chk(got_l[i] == exp_l[i], req, got_l[i], exp_l[i]);
      chk(got_f[i] == exp_f[i], req, got_f[i], exp_f[i]);
    end
  endtask

  // three-entry list at 0x100
  task automatic build_basic();
    put(32'h100, 32'h0000_0040, 32'h0000_1000);
    put(32'h108, 32'h0000_0007, 32'h0000_2004);
    put(32'h110, 32'h8000_0123, 32'h0000_3000);
    exp_a[0] = 31'h1000; exp_l[0] = 31'h40;  exp_f[0] = 1'b0;
    exp_a[1] = 31'h2004; exp_l[1] = 31'h7;   exp_f[1] = 1'b0;
    exp_a[2] = 31'h3000; exp_l[2] = 31'h123; exp_f[2] = 1'b1;
  endtask

  task automatic t_reset();
    chk(busy == 1'b0 && seg_valid == 1'b0, "R1 busy/valid in reset", {busy, seg_valid}, 0);
    chk(mem_req == 1'b0 && irq == 1'b0 && err == 1'b0, "R1 req/irq/err in reset", {mem_req, irq, err}, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk({busy, seg_valid, mem_req, irq, err} == 5'b0, "R1 after release", {busy, seg_valid, mem_req, irq, err}, 0);
  endtask

  task automatic t_list_basic();
    build_basic(); clear(); rdy_mode = 0; lat = 0;
    launch(1'b1, 1'b0, 32'h100, '0);
    wait_idle();
    cmp_segs(3, "R3 R5 basic segments");
    chk(n_rd == 6, "R5 read count", n_rd, 6);
    for (int i = 0; i < 6; i++) chk(rd_log[i] == 32'h100 + 32'(4 * i), "R2 read order", rd_log[i], 32'h100 + 4 * i);
    chk(busy == 1'b0, "R5 idle after flag", busy, 0);
  endtask

  task automatic t_mask();
    put(32'h300, 32'h7FFF_FFFF, 32'hFFFF_FFF0);
    put(32'h308, 32'hFFFF_FFFF, 32'h8000_0010);
    exp_a[0] = 31'h7FFF_FFF0; exp_l[0] = 31'h7FFF_FFFF; exp_f[0] = 1'b0;
    exp_a[1] = 31'h0000_0010; exp_l[1] = 31'h7FFF_FFFF; exp_f[1] = 1'b1;
    clear(); rdy_mode = 0; lat = 1;
    launch(1'b1, 1'b0, 32'h300, '0);
    wait_idle();
    cmp_segs(2, "R4 R3 masked fields");
  endtask

  task automatic t_backpressure();
    for (int m = 1; m <= 2; m++) begin
      put(32'h400, 32'h0000_0011, 32'h0001_0000);
      put(32'h408, 32'h0000_0022, 32'h0002_0000);
      put(32'h410, 32'h0000_0033, 32'h0003_0000);
      put(32'h418, 32'h8000_0044, 32'h0004_0000);
      for (int i = 0; i < 4; i++) begin
        exp_a[i] = 31'((i + 1) << 16); exp_l[i] = 31'(17 * (i + 1)); exp_f[i] = (i == 3);
      end
      clear(); rdy_mode = m; lat = 2;
      launch(1'b1, 1'b0, 32'h400, '0);
      wait_idle();
      cmp_segs(4, "R7 segments under stall");
      chk(hold_bad == 0, "R7 hold while stalled", hold_bad, 0);
      chk(memhold_bad == 0, "R12 request hold", memhold_bad, 0);
      chk(n_rd == 8, "R12 read count", n_rd, 8);
    end
    rdy_mode = 0;
  endtask

  task automatic t_direct();
    clear(); rdy_mode = 0; lat = 0;
    launch(1'b0, 1'b1, 32'h8000_1234, 31'h55);
    wait_idle();
    exp_a[0] = 31'h1234; exp_l[0] = 31'h55; exp_f[0] = 1'b1;
    cmp_segs(1, "R6 single buffer");
    chk(n_rd == 0, "R6 no memory read", n_rd, 0);
    chk(n_irq == 1, "R9 irq in single mode", n_irq, 1);
  endtask

  task automatic t_irq();
    build_basic(); clear(); lat = 0;
    launch(1'b1, 1'b1, 32'h100, '0);
    wait_idle();
    chk(n_irq == 1, "R9 one pulse", n_irq, 1);
    chk(irq_busy_bad == 0, "R9 pulse with busy low", irq_busy_bad, 0);
    clear();
    launch(1'b1, 1'b0, 32'h100, '0);
    wait_idle();
    chk(n_irq == 0, "R9 no pulse when disabled", n_irq, 0);
  endtask

  task automatic t_busy_ignore();
    int k = 0;
    build_basic();
    put(32'h300, 32'h8000_0999, 32'h0000_9990);
    clear(); rdy_mode = 0; lat = 3;
    launch(1'b1, 1'b0, 32'h100, '0);
    repeat (3) @(negedge clk);
    launch(1'b1, 1'b0, 32'h300, '0);
    while (!(seg_valid && seg_last) && k < 5000) begin @(negedge clk); k++; end
    cmd_base = 32'h300; cmd_list_en = 1'b1; cmd_go = 1'b1;
    @(negedge clk);
    cmd_go = 1'b0;
    repeat (10) @(negedge clk);
    cmp_segs(3, "R8 starts while busy ignored");
    chk(n_rd == 6, "R8 no extra reads", n_rd, 6);
    chk(busy == 1'b0, "R8 idle after final handshake", busy, 0);
  endtask

  task automatic t_limit(input bit flag_last);
    for (int i = 0; i < NENT; i++) begin
      logic [31:0] lw;
      lw = 32'(i + 1);
      if (flag_last && i == NENT - 1) lw[31] = 1'b1;
      put(32'h800 + 8 * i, lw, 32'(i * 32'h100));
      exp_a[i] = 31'(i * 32'h100); exp_l[i] = 31'(i + 1);
      exp_f[i] = flag_last && (i == NENT - 1);
    end
    put(32'h800 + 8 * NENT, 32'h8000_0001, 32'h0000_0000);
    clear(); rdy_mode = 2; lat = 0;
    launch(1'b1, 1'b1, 32'h800, '0);
    wait_idle();
    if (!flag_last) begin
      cmp_segs(NENT, "R10 walk cut at limit");
      chk(err == 1'b1, "R10 error raised", err, 1);
      chk(n_rd == 2 * NENT, "R10 no read past limit", n_rd, 2 * NENT);
      chk(n_irq == 1, "R10 irq at limit", n_irq, 1);
      repeat (5) @(negedge clk);
      chk(err == 1'b1, "R10 error sticky", err, 1);
      clear();
      launch(1'b0, 1'b0, 32'h10, 31'h4);
      wait_idle();
      chk(err == 1'b0, "R10 error cleared by start", err, 0);
    end else begin
      cmp_segs(NENT, "R11 flag on final entry");
      chk(err == 1'b0, "R11 no error", err, 0);
      chk(n_irq == 1, "R11 irq", n_irq, 1);
    end
    rdy_mode = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < MEMW; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    t_reset();
    t_list_basic();
    t_mask();
    t_backpressure();
    t_direct();
    t_irq();
    t_busy_ignore();
    t_limit(1'b0);
    t_limit(1'b1);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule